// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit resolves the operand of an 8-bit processor instruction once the opcode has been fetched. It is given a mode code, the program counter that points at the first operand byte, and the current X and Y index values. It then walks through the operand bytes, any pointer bytes and the final data byte over a single byte-wide read port, one read per cycle. It returns the 16-bit effective address, the byte stored at that address, and the program counter advanced past the operand.

A no-dereference input turns off indexing, pointer following and the data read. The unit then reports only the operand field as it appears in the instruction stream, which is what a disassembler needs. The memory port reads asynchronously: `mem_rdata` must reflect `mem_addr` within the same cycle. Instruction execution and flag updates belong to the caller.

Top module: `operand_ea_unit`

## Requirements
- R1: Two-byte operand fields and fetched pointers are little-endian: the byte at the lower address forms bits 7:0 and the next byte forms bits 15:8.
- R2: Mode codes 0 (implied) and 1 (accumulator) read no memory and return ea_out = 0 and value_out = 0, with pc_next equal to pc_in.
- R3: Mode code 2 (immediate) reads the byte b at pc_in and returns value_out = b, ea_out = {8'h00, b} and pc_next = pc_in + 1.
- R4: Mode codes 3, 4 and 5 (zero page, plain, +X and +Y) take the byte b at pc_in and form ea_out = {8'h00, (b + index) mod 256}, where the index is 0, X or Y. They return value_out = memory[ea_out] and pc_next = pc_in + 1.
- R5: Mode codes 6, 7 and 8 (absolute, plain, +X and +Y) read a word w at pc_in and pc_in + 1 and form ea_out = (w + index) mod 65536. They return value_out = memory[ea_out] and pc_next = pc_in + 2.
- R6: Mode code 9 (relative) takes the offset byte at pc_in as a signed value and forms ea_out = pc_in + 1 + offset (mod 65536). It returns value_out = memory[ea_out] and pc_next = pc_in + 1.
- R7: Mode code 10 (indirect) reads a pointer word p at pc_in and takes ea_out from the bytes at p and (p + 1) mod 65536. It returns value_out = memory[ea_out] and pc_next = pc_in + 2.
- R8: Mode code 11 (pre-indexed indirect) forms z = (b + X) mod 256 from the byte b at pc_in. It takes ea_out from the bytes at page-zero addresses z and (z + 1) mod 256, and returns value_out = memory[ea_out] and pc_next = pc_in + 1.
- R9: Mode code 12 (post-indexed indirect) reads a base word from page-zero addresses b and (b + 1) mod 256 and adds Y mod 65536 to form ea_out. It returns value_out = memory[ea_out] and pc_next = pc_in + 1.
- R10: With no_deref high, the unit reads only the operand bytes and applies no index. ea_out is the zero-extended byte for one-byte modes, the word for two-byte modes, and the branch target for mode 9. value_out is ea_out[7:0], and pc_next advances as in the mode's own requirement.
- R11: Mode codes 13 to 15 read no memory. bad_mode is high together with done for that single cycle, ea_out = 0, value_out = 0 and pc_next = pc_in.
- R12: After reset busy, done, bad_mode and mem_rd are low. A request accepted in cycle c (start high while busy is low) raises done for exactly one cycle, in cycle c + 1 + N, where N is the number of memory reads. mem_rd is high only in those N cycles.
- R13: start is ignored while busy is high. Inputs changed during a request do not alter its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, accepted while idle |
| mode | input | 4 | Addressing mode code |
| no_deref | input | 1 | Return raw operand field, no indexing or dereference |
| pc_in | input | 16 | Address of the first operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_rdata | input | 8 | Read data for mem_addr, same cycle |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Read address |
| busy | output | 1 | Request in progress, including the done cycle |
| done | output | 1 | Results valid, one cycle |
| bad_mode | output | 1 | Unknown mode code, pulses with done |
| ea_out | output | 16 | Effective address or raw operand field |
| value_out | output | 8 | Operand byte |
| pc_next | output | 16 | Program counter past the operand |

## Verification
Each request completes 1 + N cycles after acceptance, where N is the number of reads: 0 for implied and unknown modes, 1 for immediate, 2 to 3 for direct memory modes, 4 for the page-zero pointer modes and 5 for indirect. The bench waits on done one cycle at a time, away from the clock edge. It checks that done arrives in exactly the cycle its own model predicts and that mem_rd was seen in exactly N of those cycles. Results are compared only in the done cycle, against a model that reads the same memory function as the bench's memory. Directed cases force page-zero and 64K wraparound, negative offsets, and start pulses during busy.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
// eag_pkg: mode codes and sequencer states shared by the effective address unit.
// Assumes a 4-bit mode field; codes 13..15 are reserved and flagged as bad.
package eag_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_NONE    = 4'd0,
        MD_ACCUM   = 4'd1,
        MD_IMMED   = 4'd2,
        MD_ZPG     = 4'd3,
        MD_ZPG_X   = 4'd4,
        MD_ZPG_Y   = 4'd5,
        MD_ABSO    = 4'd6,
        MD_ABSO_X  = 4'd7,
        MD_ABSO_Y  = 4'd8,
        MD_RELAT   = 4'd9,
        MD_PTR     = 4'd10,
        MD_PREIDX  = 4'd11,
        MD_POSTIDX = 4'd12
    } eag_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP_LO,
        ST_OP_HI,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_DATA,
        ST_FIN
    } eag_state_e;

endpackage

// File: rtl/eag_mode_decode.sv
`timescale 1ns/1ps
// eag_mode_decode: classifies a mode code into operand length and fetch steps.
// Purely combinational; assumes raw (no-dereference) suppresses pointer and data reads.
module eag_mode_decode
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    input  logic              raw,
    output logic              legal,
    output logic [1:0]        opnd_bytes,
    output logic              ptr_fetch,
    output logic              data_fetch,
    output logic              zp_ptr
);

    // Decode the mode code into the steps the sequencer must run.
    always_comb begin
        legal      = 1'b1;
        opnd_bytes = 2'd0;
        ptr_fetch  = 1'b0;
        data_fetch = 1'b0;
        zp_ptr     = 1'b0;
        case (eag_mode_e'(mode_code))
            MD_NONE, MD_ACCUM: begin
                opnd_bytes = 2'd0;
            end
            MD_IMMED: begin
                opnd_bytes = 2'd1;
            end
            MD_ZPG, MD_ZPG_X, MD_ZPG_Y, MD_RELAT: begin
                opnd_bytes = 2'd1;
                data_fetch = !raw;
            end
            MD_ABSO, MD_ABSO_X, MD_ABSO_Y: begin
                opnd_bytes = 2'd2;
                data_fetch = !raw;
            end
            MD_PTR: begin
                opnd_bytes = 2'd2;
                ptr_fetch  = !raw;
                data_fetch = !raw;
            end
            MD_PREIDX, MD_POSTIDX: begin
                opnd_bytes = 2'd1;
                ptr_fetch  = !raw;
                data_fetch = !raw;
                zp_ptr     = 1'b1;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eag_addr_math.sv
`timescale 1ns/1ps
// eag_addr_math: address arithmetic for every mode (indexing, relative target,
// page-zero wrap, pointer successor). Combinational; index sums wrap modulo the
// address width, page-zero sums wrap modulo the data width.
module eag_addr_math
    import eag_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [MODE_W-1:0] mode_code,
    input  logic              raw,
    input  logic [ADDR_W-1:0] pc_base,
    input  logic [ADDR_W-1:0] opnd,
    input  logic [ADDR_W-1:0] ptr_cur,
    input  logic [ADDR_W-1:0] ptr_word,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    output logic [ADDR_W-1:0] ea_direct,
    output logic [ADDR_W-1:0] ptr_start,
    output logic [ADDR_W-1:0] ptr_succ,
    output logic [ADDR_W-1:0] ea_indirect
);

    localparam logic [DATA_W-1:0] ZHI = '0;

    logic [DATA_W-1:0] op_lo;
    logic [DATA_W-1:0] zp_plus_x;
    logic [DATA_W-1:0] zp_plus_y;
    logic [DATA_W-1:0] ptr_lo_inc;
    logic [ADDR_W-1:0] rel_target;

    // Shared partial sums used by several modes.
    always_comb begin
        op_lo      = opnd[DATA_W-1:0];
        zp_plus_x  = op_lo + idx_x;
        zp_plus_y  = op_lo + idx_y;
        ptr_lo_inc = ptr_cur[DATA_W-1:0] + DATA_W'(1);
        rel_target = pc_base + ADDR_W'(1) + {{DATA_W{op_lo[DATA_W-1]}}, op_lo};
    end

    // Effective address for modes that need no pointer fetch, or the raw field.
    always_comb begin
        ea_direct = '0;
        if (raw) begin
            case (eag_mode_e'(mode_code))
                MD_NONE, MD_ACCUM:              ea_direct = '0;
                MD_RELAT:                       ea_direct = rel_target;
                MD_ABSO, MD_ABSO_X, MD_ABSO_Y,
                MD_PTR:                         ea_direct = opnd;
                default:                        ea_direct = {ZHI, op_lo};
            endcase
        end else begin
            case (eag_mode_e'(mode_code))
                MD_IMMED, MD_ZPG: ea_direct = {ZHI, op_lo};
                MD_ZPG_X:         ea_direct = {ZHI, zp_plus_x};
                MD_ZPG_Y:         ea_direct = {ZHI, zp_plus_y};
                MD_ABSO:          ea_direct = opnd;
                MD_ABSO_X:        ea_direct = opnd + {ZHI, idx_x};
                MD_ABSO_Y:        ea_direct = opnd + {ZHI, idx_y};
                MD_RELAT:         ea_direct = rel_target;
                default:          ea_direct = '0;
            endcase
        end
    end

    // Pointer address, its successor and the post-pointer effective address.
    always_comb begin
        case (eag_mode_e'(mode_code))
            MD_PREIDX:  ptr_start = {ZHI, zp_plus_x};
            MD_POSTIDX: ptr_start = {ZHI, op_lo};
            default:    ptr_start = opnd;
        endcase
        if (eag_mode_e'(mode_code) == MD_PTR) ptr_succ = ptr_cur + ADDR_W'(1);
        else                                  ptr_succ = {ZHI, ptr_lo_inc};
        if (eag_mode_e'(mode_code) == MD_POSTIDX) ea_indirect = ptr_word + {ZHI, idx_y};
        else                                      ea_indirect = ptr_word;
    end

endmodule

// File: rtl/operand_ea_unit.sv
`timescale 1ns/1ps
// operand_ea_unit: multi-cycle operand resolver. Reads operand, pointer and data
// bytes one per cycle through an asynchronous byte read port (mem_rdata valid in
// the same cycle as mem_addr). Results are registered and valid while done is high.
module operand_ea_unit
    import eag_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              no_deref,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic              bad_mode,
    output logic [ADDR_W-1:0] ea_out,
    output logic [DATA_W-1:0] value_out,
    output logic [ADDR_W-1:0] pc_next
);

    eag_state_e        state;
    logic [MODE_W-1:0] mode_q;
    logic              raw_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] plo_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ea_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] pcn_q;
    logic              err_q;

    logic [MODE_W-1:0] dec_mode;
    logic              dec_raw;
    logic              dec_legal;
    logic [1:0]        dec_bytes;
    logic              dec_ptr;
    logic              dec_data;
    logic              dec_zp;

    logic [ADDR_W-1:0] opnd_cur;
    logic [ADDR_W-1:0] ptr_word;
    logic [ADDR_W-1:0] ea_direct;
    logic [ADDR_W-1:0] ptr_start;
    logic [ADDR_W-1:0] ptr_succ;
    logic [ADDR_W-1:0] ea_indirect;

    // Decode the live inputs while idle, the captured request otherwise.
    always_comb begin
        dec_mode = (state == ST_IDLE) ? mode : mode_q;
        dec_raw  = (state == ST_IDLE) ? no_deref : raw_q;
    end

    // Assemble the operand field and pointer word from captured and live bytes.
    always_comb begin
        opnd_cur = (state == ST_OP_HI) ? {mem_rdata, lo_q} : {{DATA_W{1'b0}}, mem_rdata};
        ptr_word = {mem_rdata, plo_q};
    end

    eag_mode_decode u_decode (
        .mode_code  (dec_mode),
        .raw        (dec_raw),
        .legal      (dec_legal),
        .opnd_bytes (dec_bytes),
        .ptr_fetch  (dec_ptr),
        .data_fetch (dec_data),
        .zp_ptr     (dec_zp)
    );

    eag_addr_math #(.DATA_W(DATA_W)) u_math (
        .mode_code   (mode_q),
        .raw         (raw_q),
        .pc_base     (pc_q),
        .opnd        (opnd_cur),
        .ptr_cur     (ptr_q),
        .ptr_word    (ptr_word),
        .idx_x       (x_q),
        .idx_y       (y_q),
        .ea_direct   (ea_direct),
        .ptr_start   (ptr_start),
        .ptr_succ    (ptr_succ),
        .ea_indirect (ea_indirect)
    );

    // Drive the read port from the current sequencer step.
    always_comb begin
        mem_rd = 1'b1;
        case (state)
            ST_OP_LO:  mem_addr = pc_q;
            ST_OP_HI:  mem_addr = pc_q + ADDR_W'(1);
            ST_PTR_LO: mem_addr = ptr_q;
            ST_PTR_HI: mem_addr = ptr_succ;
            ST_DATA:   mem_addr = ea_q;
            default: begin
                mem_addr = '0;
                mem_rd   = 1'b0;
            end
        endcase
    end

    // Sequencer: capture the request, step through the reads, present results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= '0;
            raw_q  <= 1'b0;
            pc_q   <= '0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            plo_q  <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
            val_q  <= '0;
            pcn_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q <= mode;
                        raw_q  <= no_deref;
                        pc_q   <= pc_in;
                        x_q    <= idx_x;
                        y_q    <= idx_y;
                        ea_q   <= '0;
                        val_q  <= '0;
                        err_q  <= !dec_legal;
                        pcn_q  <= dec_legal ? pc_in + ADDR_W'(dec_bytes) : pc_in;
                        state  <= (!dec_legal || dec_bytes == 2'd0) ? ST_FIN : ST_OP_LO;
                    end
                end
                ST_OP_LO, ST_OP_HI: begin
                    if (state == ST_OP_LO) lo_q <= mem_rdata;
                    if (state == ST_OP_LO && dec_bytes == 2'd2) begin
                        state <= ST_OP_HI;
                    end else if (dec_ptr) begin
                        ptr_q <= ptr_start;
                        state <= ST_PTR_LO;
                    end else begin
                        ea_q <= ea_direct;
                        if (dec_data) begin
                            state <= ST_DATA;
                        end else begin
                            val_q <= ea_direct[DATA_W-1:0];
                            state <= ST_FIN;
                        end
                    end
                end
                ST_PTR_LO: begin
                    plo_q <= mem_rdata;
                    state <= ST_PTR_HI;
                end
                ST_PTR_HI: begin
                    ea_q  <= ea_indirect;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    val_q <= mem_rdata;
                    state <= ST_FIN;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Result and status outputs.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        bad_mode  = (state == ST_FIN) && err_q;
        ea_out    = ea_q;
        value_out = val_q;
        pc_next   = pcn_q;
    end

    // R12: done lasts exactly one cycle.
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: reads happen only inside a request.
    p_read_in_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R11: an unknown mode returns zeros and leaves the program counter alone.
    p_bad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (done && ea_out == '0 && value_out == '0 && pc_next == pc_q));

    // R2: implied and accumulator requests finish in the cycle after acceptance.
    p_no_operand_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (mode == MODE_W'(0) || mode == MODE_W'(1))) |=> (done && !mem_rd));

    // R8, R9: pointer successor reads stay in page zero.
    p_zp_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_HI && dec_zp) |-> (mem_addr[ADDR_W-1:DATA_W] == '0));

    // R13: a request in progress keeps its captured inputs.
    p_hold_request_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode_q) && $stable(pc_q) && $stable(raw_q)));

    // R3: the program counter never moves by more than two operand bytes.
    p_pc_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((pc_next - pc_q) <= ADDR_W'(2)));

endmodule

// File: tb/tb_operand_ea_unit.sv
`timescale 1ns/1ps
module tb_operand_ea_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  mode;
    logic        no_deref;
    logic [15:0] pc_in;
    logic [7:0]  idx_x;
    logic [7:0]  idx_y;
    logic [7:0]  mem_rdata;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic        busy;
    logic        done;
    logic        bad_mode;
    logic [15:0] ea_out;
    logic [7:0]  value_out;
    logic [15:0] pc_next;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  salt;
    logic [15:0] ov_a [8];
    logic [7:0]  ov_d [8];
    bit          ov_v [8];

    always #2 clk = ~clk;

    operand_ea_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .no_deref(no_deref),
        .pc_in(pc_in), .idx_x(idx_x), .idx_y(idx_y), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy), .done(done),
        .bad_mode(bad_mode), .ea_out(ea_out), .value_out(value_out), .pc_next(pc_next)
    );

    function automatic logic [7:0] mb(input logic [15:0] a);
        logic [7:0] r;
        r = a[7:0] * 8'd37 + a[15:8] * 8'd11 + salt;
        for (int i = 0; i < 8; i++) if (ov_v[i] && ov_a[i] == a) r = ov_d[i];
        return r;
    endfunction

    always_comb mem_rdata = mb(mem_addr);

    task automatic clear_ov();
        for (int i = 0; i < 8; i++) ov_v[i] = 1'b0;
    endtask

    task automatic set_ov(input int i, input logic [15:0] a, input logic [7:0] d);
        ov_a[i] = a; ov_d[i] = d; ov_v[i] = 1'b1;
    endtask

    task automatic model(input int md, input bit raw, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y,
                         output logic [15:0] ea, output logic [7:0] val,
                         output logic [15:0] pcn, output bit err, output int reads);
        logic [7:0]  b0, zp, zp1;
        logic [15:0] w, rel;
        int nb;
        err = 0; ea = 0; val = 0; pcn = pc; reads = 0;
        if (md > 12) begin
            err = 1;
        end else begin
            nb = (md <= 1) ? 0 : ((md == 6 || md == 7 || md == 8 || md == 10) ? 2 : 1);
            pcn   = pc + 16'(nb);
            reads = nb;
            b0  = mb(pc);
            w   = {mb(pc + 16'd1), b0};
            rel = pc + 16'd1 + {{8{b0[7]}}, b0};
            if (raw) begin
                if (nb == 0)      ea = 0;
                else if (md == 9) ea = rel;
                else if (nb == 1) ea = {8'h00, b0};
                else              ea = w;
                val = ea[7:0];
            end else begin
                case (md)
                    2: begin ea = {8'h00, b0}; val = b0; end
                    3: ea = {8'h00, b0};
                    4: begin zp = b0 + x; ea = {8'h00, zp}; end
                    5: begin zp = b0 + y; ea = {8'h00, zp}; end
                    6: ea = w;
                    7: ea = w + {8'h00, x};
                    8: ea = w + {8'h00, y};
                    9: ea = rel;
                    10: begin ea = {mb(w + 16'd1), mb(w)}; reads += 2; end
                    11: begin zp = b0 + x; zp1 = zp + 8'd1;
                              ea = {mb({8'h00, zp1}), mb({8'h00, zp})}; reads += 2; end
                    12: begin zp1 = b0 + 8'd1;
                              ea = {mb({8'h00, zp1}), mb({8'h00, b0})} + {8'h00, y}; reads += 2; end
                    default: ea = 0;
                endcase
                if (md >= 3) begin val = mb(ea); reads += 1; end
            end
        end
    endtask

    function automatic string tag_for(input int md, input bit raw);
        if (md > 12)  return "R11";
        if (md <= 1)  return "R2";
        if (raw)      return "R10";
        case (md)
            2: return "R3";
            3, 4, 5: return "R4";
            6, 7, 8: return "R5";
            9: return "R6";
            10: return "R7";
            11: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Issue one request; optionally poke start with other inputs while busy (R13).
    task automatic run_op(input int md, input bit raw, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y,
                          input bit poke, input string tg);
        logic [15:0] e_ea, e_pcn;
        logic [7:0]  e_val;
        bit          e_err;
        int          e_reads, cyc, rdc;
        bit          got;
        string       rq;
        rq = (tg == "") ? tag_for(md, raw) : tg;
        @(negedge clk);
        mode = 4'(md); no_deref = raw; pc_in = pc; idx_x = x; idx_y = y; start = 1'b1;
        model(md, raw, pc, x, y, e_ea, e_val, e_pcn, e_err, e_reads);
        cyc = 0; rdc = 0; got = 0;
        while (!got && cyc < 20) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin
                start = 1'b1; mode = 4'd10; no_deref = ~raw; pc_in = ~pc; idx_x = ~x; idx_y = ~y;
            end else begin
                start = 1'b0;
            end
            if (mem_rd) rdc++;
            if (done) got = 1;
        end
        start = 1'b0;
        chk("R12", "done seen", 32'(got), 32'd1);
        chk("R12", "latency", 32'(cyc), 32'(e_reads + 1));
        chk("R12", "read count", 32'(rdc), 32'(e_reads));
        chk(rq, "ea_out", 32'(ea_out), 32'(e_ea));
        chk(rq, "value_out", 32'(value_out), 32'(e_val));
        chk(rq, "pc_next", 32'(pc_next), 32'(e_pcn));
        chk(rq, "bad_mode", 32'(bad_mode), 32'(e_err));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        salt = 8'h5A;
        clear_ov();
        rst_n = 1'b0; start = 1'b0; mode = '0; no_deref = 1'b0;
        pc_in = '0; idx_x = '0; idx_y = '0;
        repeat (5) @(negedge clk);
        chk("R12", "reset busy", 32'(busy), 32'd0);
        chk("R12", "reset done", 32'(done), 32'd0);
        chk("R12", "reset mem_rd", 32'(mem_rd), 32'd0);
        chk("R12", "reset bad_mode", 32'(bad_mode), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: little-endian word 0x1234 from bytes 34,12
        set_ov(0, 16'h0300, 8'h34); set_ov(1, 16'h0301, 8'h12);
        run_op(6, 0, 16'h0300, 8'h00, 8'h00, 0, "R1");
        chk("R1", "ea literal", 32'(ea_out), 32'h1234);
        clear_ov();
        // R5: absolute X wraps past 0xFFFF
        set_ov(0, 16'h0400, 8'hF0); set_ov(1, 16'h0401, 8'hFF);
        run_op(7, 0, 16'h0400, 8'h20, 8'h00, 0, "R5");
        chk("R5", "ea wrap literal", 32'(ea_out), 32'h0010);
        clear_ov();
        // R7: pointer at 0xFFFF takes its high byte from 0x0000
        set_ov(0, 16'h0500, 8'hFF); set_ov(1, 16'h0501, 8'hFF);
        set_ov(2, 16'hFFFF, 8'h78); set_ov(3, 16'h0000, 8'h56);
        run_op(10, 0, 16'h0500, 8'h00, 8'h00, 0, "R7");
        chk("R7", "ea literal", 32'(ea_out), 32'h5678);
        clear_ov();
        // R8: zero-page sum wraps; pointer high byte from page-zero wrap
        set_ov(0, 16'h0600, 8'hF0);
        run_op(11, 0, 16'h0600, 8'h20, 8'h00, 0, "R8");
        set_ov(0, 16'h0700, 8'hFF); set_ov(1, 16'h00FF, 8'h22); set_ov(2, 16'h0000, 8'h44);
        run_op(11, 0, 16'h0700, 8'h00, 8'h00, 0, "R8");
        chk("R8", "ea literal", 32'(ea_out), 32'h4422);
        clear_ov();
        // R9: base from 0xFF and 0x00, plus Y
        set_ov(0, 16'h0800, 8'hFF); set_ov(1, 16'h00FF, 8'hF0); set_ov(2, 16'h0000, 8'h12);
        run_op(12, 0, 16'h0800, 8'h00, 8'h80, 0, "R9");
        chk("R9", "ea literal", 32'(ea_out), 32'h1370);
        clear_ov();
        // R4: zero page X wraps within page zero
        set_ov(0, 16'h0900, 8'hF0);
        run_op(4, 0, 16'h0900, 8'h20, 8'h00, 0, "R4");
        chk("R4", "ea literal", 32'(ea_out), 32'h0010);
        clear_ov();
        // R6: negative offset crosses below zero; positive maximum
        set_ov(0, 16'h0005, 8'h80);
        run_op(9, 0, 16'h0005, 8'h00, 8'h00, 0, "R6");
        chk("R6", "ea literal", 32'(ea_out), 32'hFF86);
        set_ov(1, 16'h1000, 8'h7F);
        run_op(9, 0, 16'h1000, 8'h00, 8'h00, 0, "R6");
        chk("R6", "ea fwd literal", 32'(ea_out), 32'h1080);
        clear_ov();
        // R2, R3, R11, R10 directed
        run_op(0, 0, 16'h1234, 8'h11, 8'h22, 0, "R2");
        run_op(1, 1, 16'hFFFF, 8'h11, 8'h22, 0, "R2");
        run_op(2, 0, 16'hFFFF, 8'h00, 8'h00, 0, "R3");
        run_op(13, 0, 16'h4000, 8'h00, 8'h00, 0, "R11");
        run_op(15, 1, 16'h4001, 8'h00, 8'h00, 0, "R11");
        run_op(10, 1, 16'h2000, 8'h05, 8'h06, 0, "R10");
        run_op(12, 1, 16'h2100, 8'h05, 8'h06, 0, "R10");
        run_op(9, 1, 16'h2200, 8'h05, 8'h06, 0, "R10");
        // R13: start pulses during busy are ignored
        run_op(6, 0, 16'h3000, 8'h01, 8'h02, 1, "R13");
        run_op(0, 0, 16'h3100, 8'h01, 8'h02, 1, "R13");
        run_op(11, 0, 16'h3200, 8'h33, 8'h02, 1, "R13");

        for (int n = 0; n < 400; n++) begin
            salt = 8'($urandom);
            run_op($urandom_range(0, 15), ($urandom_range(0, 3) == 0), 16'($urandom),
                   8'($urandom), 8'($urandom), ($urandom_range(0, 7) == 0), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule